// File: doc/BRIEF.md
# Daisy-Chainable Vectored Interrupt Controller

This block gathers sixteen interrupt channels for an 8-bit peripheral and presents them to a processor through one active-low request line. Eight channels come from single-cycle event strobes of neighbouring on-chip logic. The other eight come from general-purpose input lines. Each of these lines passes through a synchronizer, and software picks the edge that counts on each line. Each channel has an enable bit and a mask bit. A pending bit records an event, and an optional in-service bit records a channel that is being serviced.

Software can poll the pending bits through a small address/data register port. It can also answer the request with an acknowledge cycle. In that cycle the controller that holds the chain-enable input presents an 8-bit vector: the upper bits of a software-set base with the number of the highest-priority pending channel in the low bits. The chain-enable output passes the grant to the next controller only when this one has nothing to offer. Several controllers can therefore share one acknowledge line, and their position in the chain sets their priority.

Top module: `vic_chain`

## Requirements
- R1: After reset every register reads zero, `irq_n` is high, and no channel is enabled, masked in or pending. The register map by `bus_addr` is: 0 enable ch7..0, 1 enable ch15..8, 2 mask ch7..0, 3 mask ch15..8, 4 pending ch7..0, 5 pending ch15..8, 6 in-service ch7..0, 7 in-service ch15..8, 8 edge select (bit i for `ext_in[i]`), 9 control (bits 7:4 vector base, bit 0 in-service mode). Bit k of a low register belongs to channel k, and bit k of a high register to channel k+8.
- R2: Channel i<8 is fed by `ext_in[i]` and channel 8+j by `int_evt[j]`. An event sets the channel's pending bit only when its enable bit is 1. A disabled channel's pending bit stays 0.
- R3: An edge-select bit of 1 makes the rising edge of that input line an event. A bit of 0 makes the falling edge an event. The opposite edge has no effect.
- R4: `irq_n` is low exactly when some channel that is pending and has its mask bit at 1 is also not blocked by in-service state (R9). A masked channel can still be pending without driving `irq_n` low.
- R5: Writing the pending registers clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R6: Channel 15 has the highest priority and channel 0 the lowest. The vector is {control[7:4], winning channel number[3:0]}.
- R7: While `ack` is high, `chain_in_n` is low and a request exists, `vec_valid` is high, `vec_out` carries the vector and `chain_out_n` stays high. The winner's pending bit is cleared at that clock edge. Afterwards `irq_n` is high unless other eligible channels remain pending.
- R8: With `chain_in_n` low and no request, `chain_out_n` is low. With `chain_in_n` high, `chain_out_n` is high, `vec_valid` stays low and an acknowledge changes no pending bit.
- R9: In in-service mode an acknowledge also sets the winner's in-service bit. While a channel is in service, channels of equal or lower number cannot request, and higher channels still can.
- R10: Writing the in-service registers clears every bit written as 0. This releases the channels that bit was blocking.
- R11: With in-service mode off, an acknowledge sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| ext_in | input | 8 | General-purpose interrupt input lines (asynchronous) |
| int_evt | input | 8 | Single-cycle internal event strobes |
| ack | input | 1 | Interrupt acknowledge, active high |
| chain_in_n | input | 1 | Chain enable in, active low |
| chain_out_n | output | 1 | Chain enable out, active low |
| irq_n | output | 1 | Interrupt request, active low |
| vec_valid | output | 1 | Vector on `vec_out` is being supplied |
| vec_out | output | 8 | Interrupt vector |

## Verification
The hardest state to reach from the ports is nested service: a high channel is in service above a lower one, while blocked channels of equal and lower number wait with their pending bits set. The bench reaches it in in-service mode. It acknowledges one channel, then strobes an equal channel, a lower channel and finally a higher channel, and acknowledges again. It then releases the in-service bits one at a time through register writes. After each release it checks `irq_n` and the next vector, which shows when each blocked channel is let through.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int CH_TOTAL = 16;
   localparam int BYTE_W   = 8;
   localparam int ADDR_W   = 4;
   localparam int CTRL_ISR_BIT = 0;

   typedef enum logic [ADDR_W-1:0] {
      RS_EN_LO  = 4'd0,
      RS_EN_HI  = 4'd1,
      RS_MSK_LO = 4'd2,
      RS_MSK_HI = 4'd3,
      RS_PND_LO = 4'd4,
      RS_PND_HI = 4'd5,
      RS_ISV_LO = 4'd6,
      RS_ISV_HI = 4'd7,
      RS_EDGE   = 4'd8,
      RS_CTRL   = 4'd9
   } reg_sel_e;
endpackage

// File: rtl/vic_edge_detect.sv
module vic_edge_detect #(
   parameter int LINES  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] pins,
   input  logic [LINES-1:0] rise_sel,
   output logic [LINES-1:0] hit
);
   logic [LINES-1:0] synced;
   logic [LINES-1:0] prev_q;

   if (STAGES < 1) begin : g_bad_stages
      $error("vic_edge_detect: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_sync_one
      logic [LINES-1:0] s_q;
      always_ff @(posedge clk) begin
         if (!rst_n) s_q <= '0;
         else        s_q <= pins;
      end
      assign synced = s_q;
   end else begin : g_sync_chain
      logic [STAGES-1:0][LINES-1:0] pipe_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[STAGES-2:0], pins};
      end
      assign synced = pipe_q[STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= synced;
   end

   assign hit = (synced & ~prev_q & rise_sel) | (~synced & prev_q & ~rise_sel);
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
   parameter  int N   = 16,
   localparam int IDW = $clog2(N)
) (
   input  logic [N-1:0]   req,
   output logic           any,
   output logic [IDW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) idx = IDW'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
   import vic_pkg::*;
#(
   parameter  int NUM_EXT = 8,
   parameter  int NCH     = 16,
   localparam int IDW     = $clog2(NCH),
   localparam int BASE_W  = BYTE_W - IDW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  logic [NCH-1:0]    hw_set,
   input  logic              take,
   input  logic [IDW-1:0]    take_idx,
   output logic [NCH-1:0]    en_q,
   output logic [NCH-1:0]    mask_q,
   output logic [NCH-1:0]    pend_q,
   output logic [NCH-1:0]    isr_q,
   output logic [NUM_EXT-1:0] edge_q,
   output logic [BASE_W-1:0] base_q,
   output logic              isr_mode
);
   localparam int HALF = NCH / 2;

   if (NCH != 2 * BYTE_W) begin : g_bad_nch
      $error("vic_regfile: channel count must fill two register bytes");
   end

   reg_sel_e sel;
   logic [NCH-1:0] pend_n, isr_n;
   assign sel = reg_sel_e'(addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= '0;
         mask_q   <= '0;
         edge_q   <= '0;
         base_q   <= '0;
         isr_mode <= 1'b0;
      end else if (wr_en) begin
         case (sel)
            RS_EN_LO:  en_q[HALF-1:0]     <= wdata;
            RS_EN_HI:  en_q[NCH-1:HALF]   <= wdata;
            RS_MSK_LO: mask_q[HALF-1:0]   <= wdata;
            RS_MSK_HI: mask_q[NCH-1:HALF] <= wdata;
            RS_EDGE:   edge_q             <= wdata[NUM_EXT-1:0];
            RS_CTRL: begin
               base_q   <= wdata[BYTE_W-1:IDW];
               isr_mode <= wdata[CTRL_ISR_BIT];
            end
            default: ;
         endcase
      end
   end

   // Pending: software clears, acknowledge clears, a fresh event wins over both.
   always_comb begin
      pend_n = pend_q;
      if (wr_en && sel == RS_PND_LO) pend_n[HALF-1:0]   = pend_q[HALF-1:0] & wdata;
      if (wr_en && sel == RS_PND_HI) pend_n[NCH-1:HALF] = pend_q[NCH-1:HALF] & wdata;
      if (take) pend_n[take_idx] = 1'b0;
      pend_n = pend_n | hw_set;
   end

   always_comb begin
      isr_n = isr_q;
      if (wr_en && sel == RS_ISV_LO) isr_n[HALF-1:0]   = isr_q[HALF-1:0] & wdata;
      if (wr_en && sel == RS_ISV_HI) isr_n[NCH-1:HALF] = isr_q[NCH-1:HALF] & wdata;
      if (take && isr_mode) isr_n[take_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         isr_q  <= '0;
      end else begin
         pend_q <= pend_n;
         isr_q  <= isr_n;
      end
   end

   always_comb begin
      case (sel)
         RS_EN_LO:  rdata = en_q[HALF-1:0];
         RS_EN_HI:  rdata = en_q[NCH-1:HALF];
         RS_MSK_LO: rdata = mask_q[HALF-1:0];
         RS_MSK_HI: rdata = mask_q[NCH-1:HALF];
         RS_PND_LO: rdata = pend_q[HALF-1:0];
         RS_PND_HI: rdata = pend_q[NCH-1:HALF];
         RS_ISV_LO: rdata = isr_q[HALF-1:0];
         RS_ISV_HI: rdata = isr_q[NCH-1:HALF];
         RS_EDGE:   rdata = BYTE_W'(edge_q);
         RS_CTRL:   rdata = {base_q, {(IDW-1){1'b0}}, isr_mode};
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/vic_chain.sv
module vic_chain
   import vic_pkg::*;
#(
   parameter  int NUM_EXT     = 8,
   parameter  int NUM_INT     = 8,
   parameter  int SYNC_STAGES = 2,
   localparam int NCH         = NUM_EXT + NUM_INT,
   localparam int IDW         = $clog2(NCH),
   localparam int BASE_W      = BYTE_W - IDW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [BYTE_W-1:0]  bus_wdata,
   output logic [BYTE_W-1:0]  bus_rdata,
   input  logic [NUM_EXT-1:0] ext_in,
   input  logic [NUM_INT-1:0] int_evt,
   input  logic               ack,
   input  logic               chain_in_n,
   output logic               chain_out_n,
   output logic               irq_n,
   output logic               vec_valid,
   output logic [BYTE_W-1:0]  vec_out
);
   if (NCH != CH_TOTAL) begin : g_bad_total
      $error("vic_chain: NUM_EXT + NUM_INT must equal CH_TOTAL");
   end
   if (NUM_EXT > BYTE_W) begin : g_bad_ext
      $error("vic_chain: edge select register holds at most one byte of lines");
   end

   logic [NUM_EXT-1:0] ext_hit, edge_q;
   logic [NCH-1:0]     raw_evt, hw_set, en_q, mask_q, pend_q, isr_q, active, elig;
   logic [BASE_W-1:0]  base_q;
   logic               isr_mode, isr_any, has_req, take;
   logic [IDW-1:0]     isr_top, win;

   vic_edge_detect #(.LINES(NUM_EXT), .STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins     (ext_in),
      .rise_sel (edge_q),
      .hit      (ext_hit)
   );

   assign raw_evt = {int_evt, ext_hit};
   assign hw_set  = raw_evt & en_q;

   vic_regfile #(.NUM_EXT(NUM_EXT), .NCH(NCH)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .hw_set   (hw_set),
      .take     (take),
      .take_idx (win),
      .en_q     (en_q),
      .mask_q   (mask_q),
      .pend_q   (pend_q),
      .isr_q    (isr_q),
      .edge_q   (edge_q),
      .base_q   (base_q),
      .isr_mode (isr_mode)
   );

   vic_prio_enc #(.N(NCH)) u_isr_enc (
      .req (isr_q),
      .any (isr_any),
      .idx (isr_top)
   );

   assign active = pend_q & mask_q;

   for (genvar c = 0; c < NCH; c++) begin : g_elig
      assign elig[c] = active[c] & (~isr_mode | ~isr_any | (IDW'(c) > isr_top));
   end

   vic_prio_enc #(.N(NCH)) u_req_enc (
      .req (elig),
      .any (has_req),
      .idx (win)
   );

   assign irq_n       = ~has_req;
   assign vec_valid   = ack & ~chain_in_n & has_req;
   assign take        = vec_valid;
   assign chain_out_n = chain_in_n | has_req;
   assign vec_out     = {base_q, win};
endmodule

// File: rtl/vic_chain_chk.sv
module vic_chain_chk #(
   parameter int NCH = 16,
   parameter int IDW = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           irq_n,
   input logic           chain_in_n,
   input logic           chain_out_n,
   input logic           vec_valid,
   input logic [IDW-1:0] win,
   input logic [NCH-1:0] en_q,
   input logic [NCH-1:0] mask_q,
   input logic [NCH-1:0] pend_q,
   input logic [NCH-1:0] isr_q,
   input logic [NCH-1:0] hw_set,
   input logic           isr_mode
);
   assert_idle_out_of_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> irq_n);

   assert_no_pend_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

   assert_req_needs_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (|(pend_q & mask_q)));

   assert_winner_is_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (pend_q[win] && mask_q[win]));

   assert_vector_holds_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> chain_out_n);

   assert_ack_clears_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && !hw_set[win]) |=> !pend_q[$past(win)]);

   assert_no_grant_no_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chain_in_n |-> (chain_out_n && !vec_valid));

   assert_ack_sets_isr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && isr_mode) |=> isr_q[$past(win)]);

   assert_isr_only_in_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (|(isr_q & ~$past(isr_q))) |-> $past(isr_mode));
endmodule

bind vic_chain vic_chain_chk #(.NCH(NCH), .IDW(IDW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_n       (irq_n),
   .chain_in_n  (chain_in_n),
   .chain_out_n (chain_out_n),
   .vec_valid   (vec_valid),
   .win         (win),
   .en_q        (en_q),
   .mask_q      (mask_q),
   .pend_q      (pend_q),
   .isr_q       (isr_q),
   .hw_set      (hw_set),
   .isr_mode    (isr_mode)
);

// File: tb/vic_chain_tb.sv
module vic_chain_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] bus_addr;
   logic       bus_wr;
   logic [7:0] bus_wdata, bus_rdata;
   logic [7:0] ext_in, int_evt;
   logic       ack, chain_in_n, chain_out_n, irq_n, vec_valid;
   logic [7:0] vec_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   vic_chain u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
      .int_evt(int_evt), .ack(ack), .chain_in_n(chain_in_n),
      .chain_out_n(chain_out_n), .irq_n(irq_n), .vec_valid(vec_valid),
      .vec_out(vec_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(bus_rdata === exp, req, bus_rdata, exp);
   endtask

   task automatic irq_chk(input logic exp, input string req);
      @(negedge clk);
      #1;
      chk(irq_n === exp, req, irq_n, exp);
   endtask

   task automatic pulse_int(input logic [7:0] bits);
      @(negedge clk);
      int_evt = bits;
      @(negedge clk);
      int_evt = '0;
   endtask

   task automatic set_ext(input int line, input logic v);
      @(negedge clk);
      ext_in[line] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_ack(output logic vv, output logic [7:0] vec, output logic co);
      @(negedge clk);
      ack = 1'b1;
      #1;
      vv = vec_valid; vec = vec_out; co = chain_out_n;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic t_reset();
      for (int a = 0; a < 10; a++) rd_chk(4'(a), 8'h00, "R1 register reset");
      irq_chk(1'b1, "R1 irq idle");
      #1;
      chk(chain_out_n === 1'b0, "R8 chain passes when idle", chain_out_n, 0);
   endtask

   task automatic t_enable();
      pulse_int(8'h01);
      rd_chk(4'd5, 8'h00, "R2 disabled channel stays clear");
      wr(4'd1, 8'h01);
      pulse_int(8'h01);
      rd_chk(4'd5, 8'h01, "R2 enabled channel pends");
      irq_chk(1'b1, "R4 masked pending no request");
      wr(4'd3, 8'h01);
      irq_chk(1'b0, "R4 unmasked pending requests");
      wr(4'd5, 8'hFF);
      rd_chk(4'd5, 8'h01, "R5 writing one keeps pending");
      wr(4'd5, 8'h00);
      rd_chk(4'd5, 8'h00, "R5 writing zero clears pending");
      irq_chk(1'b1, "R4 request drops after clear");
   endtask

   task automatic t_edge();
      wr(4'd0, 8'h08);
      set_ext(3, 1'b1);
      rd_chk(4'd4, 8'h00, "R3 rising ignored when falling selected");
      set_ext(3, 1'b0);
      rd_chk(4'd4, 8'h08, "R3 falling edge pends");
      wr(4'd4, 8'h00);
      wr(4'd8, 8'h08);
      rd_chk(4'd8, 8'h08, "R3 edge select readback");
      set_ext(3, 1'b1);
      rd_chk(4'd4, 8'h08, "R3 rising edge pends");
      wr(4'd4, 8'h00);
      set_ext(3, 1'b0);
      rd_chk(4'd4, 8'h00, "R3 falling ignored when rising selected");
   endtask

   task automatic t_vector();
      logic vv, co; logic [7:0] vec;
      wr(4'd0, 8'hFF); wr(4'd1, 8'hFF); wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
      wr(4'd9, 8'hA0);
      pulse_int(8'h24);
      irq_chk(1'b0, "R4 two channels request");
      do_ack(vv, vec, co);
      chk(vv === 1'b1, "R7 vector valid", vv, 1);
      chk(vec === 8'hAD, "R6 highest channel vector", vec, 8'hAD);
      chk(co === 1'b1, "R7 chain held during vector", co, 1);
      rd_chk(4'd5, 8'h04, "R7 only winner cleared");
      irq_chk(1'b0, "R7 request stays with more pending");
      do_ack(vv, vec, co);
      chk(vec === 8'hAA, "R6 next channel vector", vec, 8'hAA);
      rd_chk(4'd5, 8'h00, "R7 last pending cleared");
      irq_chk(1'b1, "R7 request drops when empty");
      rd_chk(4'd7, 8'h00, "R11 no in-service without mode");
   endtask

   task automatic t_chain();
      logic vv, co; logic [7:0] vec;
      pulse_int(8'h01);
      @(negedge clk); chain_in_n = 1'b1;
      do_ack(vv, vec, co);
      chk(vv === 1'b0, "R8 no vector without grant", vv, 0);
      chk(co === 1'b1, "R8 chain out negated without grant", co, 1);
      rd_chk(4'd5, 8'h01, "R8 ungranted ack leaves pending");
      @(negedge clk); chain_in_n = 1'b0;
      #1;
      chk(chain_out_n === 1'b1, "R8 chain blocked by own request", chain_out_n, 1);
      wr(4'd5, 8'h00);
      #1;
      chk(chain_out_n === 1'b0, "R8 chain passes after clear", chain_out_n, 0);
   endtask

   task automatic t_isr();
      logic vv, co; logic [7:0] vec;
      wr(4'd9, 8'hA1);
      pulse_int(8'h10);
      do_ack(vv, vec, co);
      chk(vec === 8'hAC, "R9 vector for channel 12", vec, 8'hAC);
      rd_chk(4'd7, 8'h10, "R9 in-service bit set");
      rd_chk(4'd5, 8'h00, "R9 pending cleared on ack");
      pulse_int(8'h10);
      irq_chk(1'b1, "R9 equal channel blocked");
      pulse_int(8'h02);
      irq_chk(1'b1, "R9 lower channel blocked");
      pulse_int(8'h40);
      irq_chk(1'b0, "R9 higher channel requests");
      do_ack(vv, vec, co);
      chk(vec === 8'hAE, "R9 nested vector channel 14", vec, 8'hAE);
      rd_chk(4'd7, 8'h50, "R9 nested in-service bits");
      irq_chk(1'b1, "R9 all pending blocked");
      wr(4'd7, 8'h10);
      irq_chk(1'b1, "R10 partial release keeps block");
      wr(4'd7, 8'h00);
      irq_chk(1'b0, "R10 full release requests");
      do_ack(vv, vec, co);
      chk(vec === 8'hAC, "R10 released channel 12 wins", vec, 8'hAC);
   endtask

   initial begin
      rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
      ext_in = '0; int_evt = '0; ack = 1'b0; chain_in_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable();
      t_edge();
      t_vector();
      t_chain();
      t_isr();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule